// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the target side of a two-wire serial memory. It is clocked by a fast system clock. It samples the bus clock line and the incoming data line through synchronizers and watches them for start and stop conditions. While a transfer is open, it counts bus clock pulses and decodes each one as a command bit, an address bit, a data bit or an acknowledge slot. Data bits either go into a byte array held inside the block or come out of it. The block never drives the wire itself. It presents one output bit that an open-drain pad outside the block puts onto the bus.

A static selector picks one of three framings. The compact framing serves a 128-byte array. Its first byte carries a 7-bit word address with the read flag in bit 0, and there is no device byte. The short framing sends a device byte first, then one address byte, and three device bits widen that address. The long framing sends a device byte and then two address bytes. Writes that run on past one byte advance only the low address bits, so they wrap inside a small page. Reads advance the full address.

Top module: `twi_eeprom_top`

## Requirements
- R1: A start is a falling data line while the clock line stays high. It opens a transfer and clears the pulse count. A stop is a rising data line while the clock stays high, and it closes the transfer. While no transfer is open, clock pulses change no memory byte.
- R2: While a transfer is open, each rising clock edge advances the pulse count before that pulse is decoded. Incoming bits are taken on the falling clock edge, most significant bit first.
- R3: Pulses 9, 18 and 27 are acknowledge slots. The block drives 0 through the whole high phase of such a pulse and stores no bit from it.
- R4: In compact mode (modeSel = 0), pulses 1 to 8 carry a 7-bit word address followed by the read flag (1 = read). Write data then fills pulses 10 to 17, and the array is 128 bytes.
- R5: In compact mode, pulse 18 folds back to slot 9. In a read, the word address then steps by one and wraps from 127 to 0.
- R6: In a compact-mode write, each completed data byte steps only the low 2 address bits, so a burst wraps inside an aligned 4-byte page.
- R7: In short mode (modeSel = 1), pulses 1 to 8 carry a device byte whose bit 0 is the read flag, and pulses 10 to 17 carry address bits 7..0. Once that address byte is complete, device bits 3..1 become address bits 10..8. Data uses pulses 19 to 26, and the count folds from 27 back to 18.
- R8: In long mode (modeSel = 2), pulses 10 to 17 and 19 to 26 carry a 16-bit address, of which the low 13 bits are kept. Data uses pulses 28 to 35, and the count folds from 36 back to 27.
- R9: In a short-mode or long-mode write, each completed data byte steps only the low 4 address bits, so a burst wraps inside an aligned 16-byte page.
- R10: In a short-mode or long-mode read, the device byte is followed by data on pulses 10 to 17. Pulse 18 folds back to 9 and the full address steps by one. The address is set beforehand by a write that carries no data.
- R11: Read data leaves the block MSB first. The bit index is 17 minus the pulse number. Outside a read data pulse and outside an acknowledge slot, the output copies the synchronized data line. The output changes only while the synchronized clock is low.
- R12: After reset the output is 1 and every memory byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| modeSel | input | 2 | Framing select: 0 compact, 1 short, 2 or 3 long; change it only while no transfer is open |
| sdaOut | output | 1 | Value for the open-drain data pad (0 pulls low) |

## Verification
A level change on either bus line reaches the decoder SYNC_STAGES+1 system clocks later, and the output register reloads at most one clock after that, while the clock line stays low. The bench therefore holds every bus phase for six system clocks. It samples the output at the very end of each high phase, after both synchronizer paths and the output register have settled. Memory contents take effect only through later read transfers. Every stored byte is checked by reading it back over the bus and comparing it with a bench model. That model applies the page-wrap and address-step rules on its own.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

  localparam int CNT_W  = 6;
  localparam int ADDR_W = 13;

  typedef enum logic [1:0] {
    MODE_COMPACT = 2'd0,
    MODE_SHORT   = 2'd1,
    MODE_LONG    = 2'd2
  } eeMode_e;

  typedef struct packed {
    logic shiftDev;
    logic shiftAddr;
    logic mergeDev;
    logic writeBit;
    logic pageStep;
    logic readStep;
    logic bitVal;
  } eeStrobe_t;

  function automatic logic isAckSlot(input logic [CNT_W-1:0] c);
    return (c == 6'd9) || (c == 6'd18) || (c == 6'd27);
  endfunction

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RST_VAL}};
    else       pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/twi_ctrl.sv
module twi_ctrl
  import twi_eeprom_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [1:0]       modeSel,
  input  logic             rwFlag,
  output eeStrobe_t        strb,
  output logic             started,
  output logic [CNT_W-1:0] cycCnt,
  output logic [CNT_W-1:0] cycLook,
  output logic             sclSync,
  output logic             sdaSync
);
  logic sclPrev, sdaPrev;
  logic bothHigh, startEv, stopEv, riseEv, fallEv;
  logic isCompact, isShort, dataRegion, readWrap;
  logic [CNT_W-1:0] cycInc;

  twi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclSync (
    .clk(clk), .rstN(rstN), .d(sclIn), .q(sclSync));
  twi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sdaSync (
    .clk(clk), .rstN(rstN), .d(sdaIn), .q(sdaSync));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end
  end

  assign isCompact = (modeSel == MODE_COMPACT);
  assign isShort   = (modeSel == MODE_SHORT);
  assign bothHigh  = sclSync & sclPrev;
  assign startEv   = bothHigh & sdaPrev & ~sdaSync;
  assign stopEv    = bothHigh & ~sdaPrev & sdaSync;
  assign riseEv    = started & ~sclPrev & sclSync;
  assign fallEv    = started & sclPrev & ~sclSync;
  assign cycInc    = cycCnt + 6'd1;
  assign dataRegion = isShort ? (cycCnt > 6'd18) : (cycCnt > 6'd27);

  // count value the next rising edge will store, with fold-backs applied
  always_comb begin
    cycLook  = cycInc;
    readWrap = 1'b0;
    if (isCompact) begin
      if (cycInc == 6'd18) begin
        cycLook  = 6'd9;
        readWrap = rwFlag;
      end
    end else if (rwFlag && cycInc == 6'd18) begin
      cycLook  = 6'd9;
      readWrap = 1'b1;
    end else if (isShort && cycInc == 6'd27) begin
      cycLook = 6'd18;
    end else if (cycInc == 6'd36) begin
      cycLook = 6'd27;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      started <= 1'b0;
      cycCnt  <= '0;
    end else begin
      if (startEv) begin
        started <= 1'b1;
        cycCnt  <= '0;
      end else if (stopEv) begin
        started <= 1'b0;
      end else if (riseEv) begin
        cycCnt <= cycLook;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.bitVal   = sdaSync;
    strb.readStep = riseEv & readWrap;
    if (fallEv) begin
      if (isCompact) begin
        if (cycCnt >= 6'd1 && cycCnt <= 6'd8) begin
          strb.shiftAddr = 1'b1;
        end else if (cycCnt >= 6'd10 && cycCnt <= 6'd17 && !rwFlag) begin
          strb.writeBit = 1'b1;
          strb.pageStep = (cycCnt == 6'd17);
        end
      end else if (isAckSlot(cycCnt)) begin
        strb.writeBit = 1'b0;
      end else if (dataRegion) begin
        if (!rwFlag) begin
          strb.writeBit = 1'b1;
          strb.pageStep = (cycCnt == 6'd26) || (cycCnt == 6'd35);
        end
      end else if (cycCnt > 6'd9) begin
        if (!rwFlag) begin
          strb.shiftAddr = 1'b1;
          strb.mergeDev  = isShort && (cycCnt == 6'd17);
        end
      end else if (cycCnt >= 6'd1) begin
        strb.shiftDev = 1'b1;
      end
    end
  end
endmodule

// File: rtl/twi_datapath.sv
module twi_datapath
  import twi_eeprom_pkg::*;
#(
  parameter int MEM_AW = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  eeStrobe_t        strb,
  input  logic             started,
  input  logic [CNT_W-1:0] cycLook,
  input  logic             sclSync,
  input  logic             sdaSync,
  output logic             rwFlag,
  output logic             sdaOut
);
  localparam int MEM_DEPTH = 1 << MEM_AW;

  logic [7:0]        devReg;
  logic [ADDR_W-1:0] addrReg, addrNext, addrShift;
  logic [7:0]        memArr [MEM_DEPTH];
  logic [MEM_AW-1:0] memIdx;
  logic [ADDR_W-1:0] compactIdx;
  logic [CNT_W-1:0]  bitDist;
  logic              isCompact, isLong, outNext;

  assign isCompact  = (modeSel == MODE_COMPACT);
  assign isLong     = !isCompact && (modeSel != MODE_SHORT);
  assign rwFlag     = isCompact ? addrReg[0] : devReg[0];
  assign compactIdx = {6'b0, addrReg[7:1]};
  assign memIdx     = isCompact ? compactIdx[MEM_AW-1:0] : addrReg[MEM_AW-1:0];
  assign addrShift  = {addrReg[ADDR_W-2:0], strb.bitVal};

  always_comb begin
    addrNext = addrReg;
    if (strb.shiftAddr) begin
      addrNext = isLong ? addrShift : {5'b0, addrShift[7:0]};
      if (strb.mergeDev) addrNext[10:8] = devReg[3:1];
    end else if (strb.pageStep) begin
      if (isCompact) addrNext = {addrReg[12:3], addrReg[2:1] + 2'd1, addrReg[0]};
      else           addrNext = {addrReg[12:4], addrReg[3:0] + 4'd1};
    end else if (strb.readStep) begin
      if (isCompact) addrNext = {5'b0, addrReg[7:1] + 7'd1, addrReg[0]};
      else           addrNext = addrReg + 13'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devReg  <= '0;
      addrReg <= '0;
    end else begin
      addrReg <= addrNext;
      if (strb.shiftDev) devReg <= {devReg[6:0], strb.bitVal};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) memArr[i] <= 8'hFF;
    end else if (strb.writeBit) begin
      memArr[memIdx] <= {memArr[memIdx][6:0], strb.bitVal};
    end
  end

  assign bitDist = 6'd17 - cycLook;

  always_comb begin
    outNext = sdaSync;
    if (started) begin
      if (isAckSlot(cycLook))
        outNext = 1'b0;
      else if (cycLook > 6'd9 && cycLook < 6'd18 && rwFlag)
        outNext = memArr[memIdx][bitDist[2:0]];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         sdaOut <= 1'b1;
    else if (!sclSync) sdaOut <= outNext;
  end
endmodule

// File: rtl/twi_eeprom_top.sv
module twi_eeprom_top
  import twi_eeprom_pkg::*;
#(
  parameter int MEM_AW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [1:0] modeSel,
  output logic       sdaOut
);
  eeStrobe_t        strb;
  logic             started, rwFlag, sclSync, sdaSync;
  logic [CNT_W-1:0] cycCnt, cycLook;

  twi_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .modeSel(modeSel),
    .rwFlag(rwFlag), .strb(strb), .started(started), .cycCnt(cycCnt),
    .cycLook(cycLook), .sclSync(sclSync), .sdaSync(sdaSync));

  twi_datapath #(.MEM_AW(MEM_AW)) u_data (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .strb(strb), .started(started),
    .cycLook(cycLook), .sclSync(sclSync), .sdaSync(sdaSync),
    .rwFlag(rwFlag), .sdaOut(sdaOut));
endmodule

// File: rtl/twi_eeprom_checker.sv
module twi_eeprom_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic       sclSync,
  input logic       sdaSync,
  input logic       started,
  input logic [5:0] cycCnt,
  input logic       sdaOut
);
  assert_start_opens_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sclSync && $past(sclSync) && $past(sdaSync) && !sdaSync) |=> (started && cycCnt == 6'd0));

  assert_stop_closes_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sclSync && $past(sclSync) && !$past(sdaSync) && sdaSync) |=> !started);

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    started |-> (cycCnt < 6'd36));

  assert_compact_fold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (started && modeSel == 2'd0) |-> (cycCnt < 6'd18));

  assert_ack_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (started && sclSync && $past(sclSync) &&
     (cycCnt == 6'd9 || cycCnt == 6'd18 || cycCnt == 6'd27)) |-> !sdaOut);

  assert_out_low_phase_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOut) |-> !$past(sclSync));
endmodule

bind twi_eeprom_top twi_eeprom_checker u_checker (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .sclSync(sclSync), .sdaSync(sdaSync),
  .started(started), .cycCnt(cycCnt), .sdaOut(sdaOut));

// File: tb/test_twi_eeprom_top.sv
`timescale 1ns/1ps
module test_twi_eeprom_top;
  localparam int Q = 6;
  localparam int DEPTH = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1;
  logic sdaDrv = 1'b1;
  logic [1:0] modeDrv = 2'd0;
  logic sdaOut;
  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];

  always #2.5 clk = ~clk;

  twi_eeprom_top #(.MEM_AW(10), .SYNC_STAGES(2)) i_twi_eeprom_top (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaDrv),
    .modeSel(modeDrv), .sdaOut(sdaOut));

  task automatic checkVal(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic setLine(input logic s, input logic d);
    sclDrv = s;
    sdaDrv = d;
    waitQ();
  endtask

  task automatic busStart();
    if (!sclDrv) begin
      setLine(1'b0, 1'b1);
      setLine(1'b1, 1'b1);
    end
    setLine(1'b1, 1'b0);
    setLine(1'b0, 1'b0);
  endtask

  task automatic busStop();
    setLine(1'b0, 1'b0);
    setLine(1'b1, 1'b0);
    setLine(1'b1, 1'b1);
  endtask

  task automatic pulse(input logic d, output logic got);
    setLine(1'b0, d);
    sclDrv = 1'b1;
    waitQ();
    got = sdaOut;
    sclDrv = 1'b0;
    waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, input string req);
    logic g;
    for (int i = 7; i >= 0; i--) pulse(b[i], g);
    pulse(1'b1, g);
    checkVal({req, " ack R3"}, g, 0);
  endtask

  task automatic recvByte(output logic [7:0] b);
    logic g;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      pulse(1'b1, g);
      b = {b[6:0], g};
    end
    pulse(1'b1, g);
    checkVal("R3 read ack slot", g, 0);
  endtask

  // R4 R6: compact write, page of 4
  task automatic compactWrite(input int a, input int n);
    logic [7:0] d;
    busStart();
    sendByte({a[6:0], 1'b0}, "R4");
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      sendByte(d, "R2");
      model[(a & 'h7C) | ((a + i) & 3)] = d;
    end
    busStop();
  endtask

  // R4 R5: compact read, wraps in 128
  task automatic compactRead(input int a, input int n, input string req);
    logic [7:0] g;
    busStart();
    sendByte({a[6:0], 1'b1}, req);
    for (int i = 0; i < n; i++) begin
      recvByte(g);
      checkVal(req, g, model[(a + i) & 127]);
    end
    busStop();
  endtask

  task automatic sendAddr(input int m, input int a, input string req);
    logic [7:0] dev;
    dev = (m == 1) ? {4'hA, 3'(a >> 8), 1'b0} : 8'hA0;
    sendByte(dev, req);
    if (m == 2) sendByte(8'(a >> 8), req);
    sendByte(8'(a), req);
  endtask

  // R9: paged write, page of 16
  task automatic pagedWrite(input int m, input int a, input int n);
    logic [7:0] d;
    modeDrv = 2'(m);
    busStart();
    sendAddr(m, a, "R7");
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      sendByte(d, "R2");
      model[(a & ~15) | ((a + i) & 15)] = d;
    end
    busStop();
  endtask

  // R10: address-only write, restart, sequential read
  task automatic pagedRead(input int m, input int a, input int n, input string req);
    logic [7:0] g;
    logic [7:0] dev;
    modeDrv = 2'(m);
    busStart();
    sendAddr(m, a, req);
    busStart();
    dev = (m == 1) ? {4'hA, 3'(a >> 8), 1'b1} : 8'hA1;
    sendByte(dev, req);
    for (int i = 0; i < n; i++) begin
      recvByte(g);
      checkVal(req, g, model[(a + i) & (DEPTH - 1)]);
    end
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int seedVal;
    logic g;
    seedVal = $urandom(32'd4242);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R12 reset state
    checkVal("R12 output after reset", sdaOut, 1);
    compactRead('h55, 1, "R12");

    // R11 echo while idle and SCL low
    setLine(1'b0, 1'b1);
    setLine(1'b0, 1'b0);
    checkVal("R11 echo low", sdaOut, 0);
    setLine(1'b0, 1'b1);
    checkVal("R11 echo high", sdaOut, 1);

    // R1 pulses with no start change nothing
    for (int i = 0; i < 18; i++) pulse(1'b0, g);
    setLine(1'b0, 1'b1);
    setLine(1'b1, 1'b1);
    compactRead('h00, 2, "R1");

    // R4 R6 compact write with page wrap
    compactWrite('h16, 4);
    compactRead('h14, 4, "R6");
    compactWrite('h40, 1);
    compactRead('h40, 1, "R4");

    // R5 compact read wraps 127 -> 0
    compactWrite('h7E, 2);
    compactWrite('h00, 1);
    compactRead('h7E, 3, "R5");

    // R7 short mode with device bits
    pagedWrite(1, 'h2F3, 2);
    pagedRead(1, 'h2F3, 2, "R7");
    pagedRead(1, 'h0F3, 1, "R7");

    // R8 long mode
    pagedWrite(2, 'h3A5, 3);
    pagedRead(2, 'h3A5, 3, "R8");

    // R9 page wrap of 16
    pagedWrite(1, 'h10E, 4);
    pagedRead(1, 'h10D, 5, "R9");
    pagedWrite(2, 'h21C, 6);
    pagedRead(2, 'h210, 16, "R9");

    // R10 sequential read crossing a page
    pagedWrite(2, 'h0FE, 2);
    pagedRead(2, 'h0FE, 4, "R10");

    // random transfers, R2
    for (int k = 0; k < 8; k++) begin
      int m, a, n;
      m = 1 + int'($urandom % 2);
      a = int'($urandom % DEPTH);
      n = 1 + int'($urandom % 6);
      pagedWrite(m, a, n);
      pagedRead(m, a & ~15, 16, "R2");
    end
    for (int k = 0; k < 3; k++) begin
      int a, n;
      modeDrv = 2'd0;
      a = int'($urandom % 128);
      n = 1 + int'($urandom % 4);
      compactWrite(a, n);
      compactRead(a & 'h7C, 4, "R2");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule